// File: doc/BRIEF.md
# Mode-Dependent Port With Pull-Ups

This block controls an eight-pin bidirectional microcontroller port. It holds three byte-wide registers on a small register bus: pull-up enables, pin direction and output data. From these registers, the operating mode and two standby inputs, it drives a per-pin output enable, an output value and a pull-up enable. It also samples the pin levels through a synchronizer so that software can read them.

The operating mode decides how each pin is used. In the expanded mode without internal program memory, every pin carries external address. In the expanded mode with internal memory, each pin's direction bit picks between an address output and a general input. In single-chip mode, the port is plain general-purpose I/O. Hardware standby shuts the port off and clears its state. Software standby freezes the state and parks the address pins low.

Top module: `port_mux_ctrl`

## Requirements
- R1: Bus offset 0 is the pull-up register, offset 1 the direction register and offset 2 the data register. Offset 3 reads 0x00. Reads are combinational. A write takes effect on the rising edge on which `bus_wr` is high, and bit n of each register belongs to pin n.
- R2: After reset the pull-up, data and direction registers read 0x00 (direction 0xFF in mode 1), and no pull-up is enabled.
- R3: In mode 1 (`mode`=1) the direction register reads 0xFF and ignores writes. Every pin is enabled and drives the matching `addr_out` bit, and every pull-up is off.
- R4: In mode 2 a pin whose direction bit is 1 is enabled and drives its `addr_out` bit. A pin whose direction bit is 0 is an undriven input.
- R5: In mode 3 (and mode 0) a pin whose direction bit is 1 is enabled and drives its data register bit. A pin whose direction bit is 0 is an input. An undriven pin always has `pin_out`=0.
- R6: `pin_pu[n]` is 1 exactly when the mode is not 1, the effective direction bit n is 0, pull-up bit n is 1 and hardware standby is low.
- R7: While `hw_stby` is high, all outputs are 0 (`pin_oe`, `pin_out`, `pin_pu`) and bus writes are ignored. At each rising edge the pull-up and data registers clear, and the direction register clears outside mode 1. Hardware standby overrides software standby.
- R8: While only `sw_stby` is high, all registers hold and bus writes are ignored. Address pins drive 0, and general output pins keep driving the data register.
- R9: A read of offset 2 returns the data register bit for pins whose effective direction is 1. For the other pins it returns the pin level through a two-flop synchronizer, visible after the second rising edge following the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating mode: 1 address-only, 2 mixed, 3 or 0 single-chip |
| hw_stby | input | 1 | Hardware standby request |
| sw_stby | input | 1 | Software standby request |
| bus_addr | input | 2 | Register offset for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| addr_out | input | 8 | Address byte routed to address pins |
| pin_in | input | 8 | Pin levels from the pads |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |
| pin_pu | output | 8 | Per-pin pull-up enable |

## Verification
Two events can collide in one cycle: a register write and a standby request. The bench provokes this by holding a write strobe with a fresh value while software standby is raised, and again while both standby inputs are raised together. A correct result has the registers read back at their earlier value under software standby and at their cleared value under hardware standby. The pins must show the standby view in both cases: address pins low under software standby, and everything off under hardware standby.

// File: rtl/port_mux_pkg.sv
package port_mux_pkg;
    typedef enum logic [1:0] {
        MODE_SC_ALT = 2'd0,
        MODE_ADDR   = 2'd1,
        MODE_MIXED  = 2'd2,
        MODE_SC     = 2'd3
    } port_mode_e;

    localparam int OFF_PU  = 0;
    localparam int OFF_DIR = 1;
    localparam int OFF_DAT = 2;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    logic [W-1:0] st_d [STAGES];
    logic [W-1:0] st_q [STAGES];

    always_comb begin
        st_d[0] = raw;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) st_q[i] <= st_d[i];
        end
    end

    assign synced = st_q[STAGES-1];
endmodule

// File: rtl/port_regs.sv
module port_regs
    import port_mux_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          hw_stby,
    input  logic          sw_stby,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  pu_q,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  dat_q
);
    typedef struct packed {
        logic [W-1:0] pu;
        logic [W-1:0] dir;
        logic [W-1:0] dat;
    } regs_t;

    regs_t r_d, r_q;
    logic  locked;

    always_comb begin
        r_d    = r_q;
        locked = (mode == MODE_ADDR);
        if (locked) r_d.dir = '1;
        if (hw_stby) begin
            r_d.pu  = '0;
            r_d.dat = '0;
            if (!locked) r_d.dir = '0;
        end else if (!sw_stby && wr_en) begin
            if (wr_addr == AW'(OFF_PU))              r_d.pu  = wr_data;
            if (wr_addr == AW'(OFF_DIR) && !locked)  r_d.dir = wr_data;
            if (wr_addr == AW'(OFF_DAT))             r_d.dat = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pu_q  = r_q.pu;
    assign dir_q = r_q.dir;
    assign dat_q = r_q.dat;
endmodule

// File: rtl/pin_mux.sv
module pin_mux
    import port_mux_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = 2
) (
    input  logic [1:0]    mode,
    input  logic          hw_stby,
    input  logic          sw_stby,
    input  logic [W-1:0]  pu_q,
    input  logic [W-1:0]  dir_q,
    input  logic [W-1:0]  dat_q,
    input  logic [W-1:0]  addr_out,
    input  logic [W-1:0]  sync_in,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  pin_oe,
    output logic [W-1:0]  pin_out,
    output logic [W-1:0]  pin_pu,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] dir_eff, addr_sel, addr_val;

    always_comb begin
        dir_eff  = (mode == MODE_ADDR) ? '1 : dir_q;
        addr_sel = (mode == MODE_ADDR)  ? '1 :
                   (mode == MODE_MIXED) ? dir_eff : '0;
        addr_val = sw_stby ? '0 : addr_out;
        for (int n = 0; n < W; n++) begin
            if (hw_stby) begin
                pin_oe[n]  = 1'b0;
                pin_out[n] = 1'b0;
                pin_pu[n]  = 1'b0;
            end else begin
                pin_oe[n]  = dir_eff[n];
                pin_out[n] = addr_sel[n] ? addr_val[n] : (dir_eff[n] & dat_q[n]);
                pin_pu[n]  = (mode != MODE_ADDR) & ~dir_eff[n] & pu_q[n];
            end
        end
        if (rd_addr == AW'(OFF_PU))       rd_data = pu_q;
        else if (rd_addr == AW'(OFF_DIR)) rd_data = dir_eff;
        else if (rd_addr == AW'(OFF_DAT)) rd_data = (dir_eff & dat_q) | (~dir_eff & sync_in);
        else                              rd_data = '0;
    end
endmodule

// File: rtl/port_mux_ctrl.sv
module port_mux_ctrl #(
    parameter int W  = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          hw_stby,
    input  logic          sw_stby,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic [W-1:0]  addr_out,
    input  logic [W-1:0]  pin_in,
    output logic [W-1:0]  pin_oe,
    output logic [W-1:0]  pin_out,
    output logic [W-1:0]  pin_pu
);
    logic [W-1:0] reg_pu, reg_dir, reg_dat, sync_in;

    pin_sync #(.W(W), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(pin_in), .synced(sync_in)
    );

    port_regs #(.W(W), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .mode(mode), .hw_stby(hw_stby),
        .sw_stby(sw_stby), .wr_en(bus_wr), .wr_addr(bus_addr),
        .wr_data(bus_wdata), .pu_q(reg_pu), .dir_q(reg_dir), .dat_q(reg_dat)
    );

    pin_mux #(.W(W), .AW(AW)) u_mux (
        .mode(mode), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .pu_q(reg_pu), .dir_q(reg_dir), .dat_q(reg_dat),
        .addr_out(addr_out), .sync_in(sync_in), .rd_addr(bus_addr),
        .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu), .rd_data(bus_rdata)
    );
endmodule

// File: rtl/port_mux_chk.sv
module port_mux_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   mode,
    input logic         hw_stby,
    input logic         sw_stby,
    input logic [W-1:0] pin_oe,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] pin_pu,
    input logic [W-1:0] reg_pu,
    input logic [W-1:0] reg_dir,
    input logic [W-1:0] reg_dat
);
    a_r7_pins_off: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |-> (pin_oe == '0 && pin_out == '0 && pin_pu == '0));

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (reg_pu == '0 && reg_dat == '0));

    a_r6_pu_inputs_only: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & pin_oe) == '0);

    a_r3_all_address: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && !hw_stby) |-> (pin_oe == '1 && pin_pu == '0));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && !hw_stby) |=> ($stable(reg_pu) && $stable(reg_dat)));

    a_r8_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && !hw_stby && mode != 2'd1) |=> $stable(reg_dir));

    a_r8_addr_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && !hw_stby && mode == 2'd1) |-> (pin_out == '0));
endmodule

bind port_mux_ctrl port_mux_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu),
    .reg_pu(reg_pu), .reg_dir(reg_dir), .reg_dat(reg_dat)
);

// File: tb/sim_port_mux_ctrl.sv
`timescale 1ns/1ps
module sim_port_mux_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd3;
    logic       hw_stby = 1'b0, sw_stby = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00, bus_rdata;
    logic [7:0] addr_out = 8'h00, pin_in = 8'h00;
    logic [7:0] pin_oe, pin_out, pin_pu;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [7:0] m_pu, m_dir, m_dat;

    always #2.5 clk = ~clk;

    port_mux_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .addr_out(addr_out), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic check_all(input int md);
        logic [7:0] de, asel, e_out, e_pu, v;
        string tm;
        tm   = (md == 1) ? "R3" : (md == 2) ? "R4" : "R5";
        de   = (md == 1) ? 8'hFF : m_dir;
        asel = (md == 1) ? 8'hFF : (md == 2) ? de : 8'h00;
        e_out = (asel & (sw_stby ? 8'h00 : addr_out)) | (~asel & de & m_dat);
        e_pu  = (md == 1) ? 8'h00 : (~de & m_pu);
        chk(tm, "pin_oe", pin_oe, de);
        chk(tm, "pin_out", pin_out, e_out);
        chk("R6", "pin_pu", pin_pu, e_pu);
        rd(2'd0, v); chk("R1", "read pu", v, m_pu);
        rd(2'd1, v); chk(tm, "read dir", v, de);
        rd(2'd2, v); chk("R9", "read data", v, (de & m_dat) | (~de & pin_in));
        rd(2'd3, v); chk("R1", "read off3", v, 8'h00);
    endtask

    initial begin
        #(150000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        for (int md = 1; md <= 3; md++) begin
            rst_n = 1'b0; mode = 2'(md); hw_stby = 1'b0; sw_stby = 1'b0;
            pin_in = 8'h00; addr_out = 8'h00;
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            m_pu = 8'h00; m_dat = 8'h00; m_dir = (md == 1) ? 8'hFF : 8'h00;
            chk("R2", "pull-ups after reset", pin_pu, 8'h00);
            rd(2'd0, v); chk("R2", "pu after reset", v, 8'h00);
            rd(2'd1, v); chk("R2", "dir after reset", v, m_dir);
            rd(2'd2, v); chk("R2", "data after reset", v, 8'h00);

            for (int k = 0; k < 24; k++) begin
                logic [7:0] pv, dv, tv;
                pv = 8'(k * 37 + 5);
                dv = 8'(k * 91 + 3);
                tv = 8'(k * 53 + 9);
                addr_out = 8'(k * 29 + 1);
                pin_in   = 8'(k * 71 + 2);
                wr(2'd0, pv); m_pu = pv;
                wr(2'd1, dv); if (md != 1) m_dir = dv;
                wr(2'd2, tv); m_dat = tv;
                wr(2'd3, 8'hA5);
                check_all(md);
            end

            // R9: synchronizer latency on an input pin
            if (md != 1) begin
                wr(2'd1, 8'h00); m_dir = 8'h00;
                @(negedge clk); pin_in = 8'h3C;
                @(negedge clk);
                rd(2'd2, v); chk("R9", "sync after one edge", v, 8'(k_prev(md)));
                @(negedge clk);
                rd(2'd2, v); chk("R9", "sync after two edges", v, 8'h3C);
            end

            // R8: write colliding with software standby is ignored
            @(negedge clk); sw_stby = 1'b1;
            wr(2'd0, ~m_pu);
            wr(2'd2, ~m_dat);
            rd(2'd0, v); chk("R8", "pu held", v, m_pu);
            check_all(md);
            sw_stby = 1'b0;

            // R7: hardware standby with software standby and a write
            @(negedge clk); hw_stby = 1'b1; sw_stby = 1'b1;
            wr(2'd0, 8'hFF);
            chk("R7", "oe off", pin_oe, 8'h00);
            chk("R7", "out off", pin_out, 8'h00);
            chk("R7", "pu off", pin_pu, 8'h00);
            hw_stby = 1'b0; sw_stby = 1'b0;
            m_pu = 8'h00; m_dat = 8'h00; m_dir = (md == 1) ? 8'hFF : 8'h00;
            #1;
            rd(2'd0, v); chk("R7", "pu cleared", v, 8'h00);
            rd(2'd1, v); chk("R7", "dir after standby", v, m_dir);
            check_all(md);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // pin level before the 0x3C step: the last sweep value, k = 23
    function automatic int k_prev(input int md);
        return (md >= 0) ? (23 * 71 + 2) : 0;
    endfunction
endmodule